// File: doc/BRIEF.md
# Debug Register Bridge with Core Register Window

This block is the debug-side register front end of a CPU core. A host drives single-beat requests on a plain register interface with a 16-bit address, a write flag and 32-bit write data. The block answers with a one-cycle response pulse that carries read data. The lower half of the address space holds a small set of local 16-bit registers: fixed identity words, two general read/write words, a core control word whose bit 0 holds the core in a stalled state, an upper-address word and a core data-width word.

Any address with bit 15 set is passed through to the core's special-purpose register port. The 15 low address bits are kept as the offset, and the upper-address word is placed directly above them. This forms a wider core register address, so a 32 KiB window can be moved across the whole core register space. The forwarded access holds its request until the core acknowledges, and the bus response follows the acknowledge.

The host issues one request and then waits for its response. It issues the next request no earlier than the cycle after that response.

Top module: `dbg_spr_bridge`

## Requirements
- R1: The identity words read as 0x0001 at address 0x0000, 0x0006 at 0x0001 and 0x0000 at 0x0002, both after reset and after any write to those addresses, which has no effect.
- R2: The words at 0x0003 and 0x0004 are 16-bit read/write, reset to 0, and read back the last value written.
- R3: The control word at 0x0200 is 16-bit read/write. Bits 15:1 reset to 0. Bit 0 resets to parameter STALL_RST, which is 0 by default.
- R4: Output core_stall equals bit 0 of the control word. It changes only as the result of a write to 0x0200, and it shows the new value in the same cycle as that write's response.
- R5: The upper-address word at 0x0201 is 16-bit read/write and resets to 0.
- R6: The data-width word at 0x0202 resets to 0. A write of 16, 32, 64 or 128 is stored. A write of any other value leaves the previous value in place.
- R7: Any address below 0x8000 other than 0x0000–0x0004 and 0x0200–0x0202 reads as 0, and a write to it changes no register.
- R8: A request to an address below 0x8000 gets its response exactly one cycle after the request is accepted, as a single-cycle pulse. Read data is the 16-bit register value with zero extension to 32 bits. A write response carries data 0.
- R9: A request to an address at or above 0x8000 raises spr_req in the next cycle. It carries spr_write, spr_wdata and spr_addr = upper_word × 2^15 + (address − 0x8000), and all of these hold steady until spr_ack is seen.
- R10: The cycle that samples spr_ack with spr_req high drops spr_req. The response pulse follows in the next cycle, with spr_rdata as read data for a read and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 32 | Write data (low 16 bits used by local registers) |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| spr_req | output | 1 | Core register access request, held until acknowledge |
| spr_write | output | 1 | Core register access is a write |
| spr_addr | output | 31 | Translated core register address |
| spr_wdata | output | 32 | Core register write data |
| spr_ack | input | 1 | Core acknowledge of the pending access |
| spr_rdata | input | 32 | Core register read data, valid with spr_ack |
| core_stall | output | 1 | Holds the core stalled while high |

## Verification
The assertions rely on the host having only one request outstanding. No req_valid arrives while a window access waits for its acknowledge, and none arrives in the cycle of a response, so the response pulse is never stretched. They also rely on the core raising spr_ack only while spr_req is high and for a single sampled cycle. The bench's host tasks wait for each response and start the next request one cycle later. Its core model acknowledges after a delay of zero to three cycles and drops spr_ack as soon as the request falls.

// File: rtl/dbg_bridge_pkg.sv
package dbg_bridge_pkg;

  localparam logic [15:0] ID_VENDOR_VAL  = 16'h0001;
  localparam logic [15:0] ID_TYPE_VAL    = 16'h0006;
  localparam logic [15:0] ID_VERSION_VAL = 16'h0000;

  localparam logic [15:0] A_VENDOR  = 16'h0000;
  localparam logic [15:0] A_TYPE    = 16'h0001;
  localparam logic [15:0] A_VERSION = 16'h0002;
  localparam logic [15:0] A_STATUS  = 16'h0003;
  localparam logic [15:0] A_EVDEST  = 16'h0004;
  localparam logic [15:0] A_CTRL    = 16'h0200;
  localparam logic [15:0] A_UPPER   = 16'h0201;
  localparam logic [15:0] A_WIDTH   = 16'h0202;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_VENDOR, SEL_TYPE, SEL_VERSION, SEL_STATUS,
    SEL_EVDEST, SEL_CTRL, SEL_UPPER, SEL_WIDTH
  } reg_sel_e;

  typedef enum logic {ST_IDLE, ST_WAIT} win_state_e;

  function automatic logic width_legal(input logic [15:0] v);
    case (v)
      16'd16, 16'd32, 16'd64, 16'd128: width_legal = 1'b1;
      default:                         width_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
  import dbg_bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              in_window
);

  assign in_window = addr[ADDR_W-1];

  always_comb begin
    sel = SEL_NONE;
    if (!in_window) begin
      case (addr)
        A_VENDOR:  sel = SEL_VENDOR;
        A_TYPE:    sel = SEL_TYPE;
        A_VERSION: sel = SEL_VERSION;
        A_STATUS:  sel = SEL_STATUS;
        A_EVDEST:  sel = SEL_EVDEST;
        A_CTRL:    sel = SEL_CTRL;
        A_UPPER:   sel = SEL_UPPER;
        A_WIDTH:   sel = SEL_WIDTH;
        default:   sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dbg_local_regs.sv
module dbg_local_regs
  import dbg_bridge_pkg::*;
#(
  parameter int   REG_W     = 16,
  parameter logic STALL_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_data,
  output logic             stall,
  output logic [REG_W-1:0] upper,
  output logic [REG_W-1:0] width
);

  localparam logic [REG_W-1:0] CTRL_RST = {{(REG_W-1){1'b0}}, STALL_RST};

  logic [REG_W-1:0] status_q, evdest_q, ctrl_q, upper_q, width_q;
  logic             status_en, evdest_en, ctrl_en, upper_en, width_en;

  always_comb begin
    status_en = wr_en && (sel == SEL_STATUS);
    evdest_en = wr_en && (sel == SEL_EVDEST);
    ctrl_en   = wr_en && (sel == SEL_CTRL);
    upper_en  = wr_en && (sel == SEL_UPPER);
    width_en  = wr_en && (sel == SEL_WIDTH) && width_legal(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      evdest_q <= '0;
      ctrl_q   <= CTRL_RST;
      upper_q  <= '0;
      width_q  <= '0;
    end else begin
      if (status_en) status_q <= wdata;
      if (evdest_en) evdest_q <= wdata;
      if (ctrl_en)   ctrl_q   <= wdata;
      if (upper_en)  upper_q  <= wdata;
      if (width_en)  width_q  <= wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_VENDOR:  rd_data = ID_VENDOR_VAL;
      SEL_TYPE:    rd_data = ID_TYPE_VAL;
      SEL_VERSION: rd_data = ID_VERSION_VAL;
      SEL_STATUS:  rd_data = status_q;
      SEL_EVDEST:  rd_data = evdest_q;
      SEL_CTRL:    rd_data = ctrl_q;
      SEL_UPPER:   rd_data = upper_q;
      SEL_WIDTH:   rd_data = width_q;
      default:     rd_data = '0;
    endcase
  end

  assign stall = ctrl_q[0];
  assign upper = upper_q;
  assign width = width_q;

endmodule

// File: rtl/dbg_spr_port.sv
module dbg_spr_port
  import dbg_bridge_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int UPPER_W = 16,
  localparam int OFF_W  = ADDR_W - 1,
  localparam int SPR_AW = UPPER_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               wr,
  input  logic [OFF_W-1:0]   offset,
  input  logic [UPPER_W-1:0] upper,
  input  logic [DATA_W-1:0]  wdata,
  output logic               spr_req,
  output logic               spr_write,
  output logic [SPR_AW-1:0]  spr_addr,
  output logic [DATA_W-1:0]  spr_wdata,
  input  logic               spr_ack,
  input  logic [DATA_W-1:0]  spr_rdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata
);

  win_state_e        st_q, st_d;
  logic [SPR_AW-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              rsp_q, rsp_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              cap_en, done_en;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    wr_d    = wr_q;
    wd_d    = wd_q;
    rd_d    = rd_q;
    rsp_d   = 1'b0;
    cap_en  = 1'b0;
    done_en = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_WAIT;
        addr_d = {upper, offset};
        wr_d   = wr;
        wd_d   = wdata;
        cap_en = 1'b1;
      end
      ST_WAIT: if (spr_ack) begin
        st_d    = ST_IDLE;
        rsp_d   = 1'b1;
        rd_d    = wr_q ? '0 : spr_rdata;
        done_en = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      rsp_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      st_q  <= st_d;
      rsp_q <= rsp_d;
      if (cap_en) begin
        addr_q <= addr_d;
        wr_q   <= wr_d;
        wd_q   <= wd_d;
      end
      if (done_en) rd_q <= rd_d;
    end
  end

  assign spr_req   = (st_q == ST_WAIT);
  assign spr_write = wr_q;
  assign spr_addr  = addr_q;
  assign spr_wdata = wd_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rd_q;

endmodule

// File: rtl/dbg_spr_bridge.sv
module dbg_spr_bridge
  import dbg_bridge_pkg::*;
#(
  parameter int   ADDR_W    = 16,
  parameter int   DATA_W    = 32,
  parameter int   REG_W     = 16,
  parameter logic STALL_RST = 1'b0,
  localparam int  SPR_AW    = REG_W + ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              spr_req,
  output logic              spr_write,
  output logic [SPR_AW-1:0] spr_addr,
  output logic [DATA_W-1:0] spr_wdata,
  input  logic              spr_ack,
  input  logic [DATA_W-1:0] spr_rdata,
  output logic              core_stall
);

  reg_sel_e          sel;
  logic              in_window;
  logic              local_hit, local_wr, win_start;
  logic [REG_W-1:0]  reg_rd, upper_q, width_q;
  logic              lrsp_q, lrsp_d;
  logic [DATA_W-1:0] lrd_q, lrd_d;
  logic              win_rsp;
  logic [DATA_W-1:0] win_rd;

  dbg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .sel(sel), .in_window(in_window)
  );

  always_comb begin
    local_hit = req_valid && !in_window;
    local_wr  = local_hit && req_write;
    win_start = req_valid && in_window;
    lrsp_d    = local_hit;
    lrd_d     = req_write ? '0 : {{(DATA_W-REG_W){1'b0}}, reg_rd};
  end

  dbg_local_regs #(.REG_W(REG_W), .STALL_RST(STALL_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(local_wr), .sel(sel),
    .wdata(req_wdata[REG_W-1:0]), .rd_data(reg_rd),
    .stall(core_stall), .upper(upper_q), .width(width_q)
  );

  dbg_spr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UPPER_W(REG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .start(win_start), .wr(req_write),
    .offset(req_addr[ADDR_W-2:0]), .upper(upper_q), .wdata(req_wdata),
    .spr_req(spr_req), .spr_write(spr_write), .spr_addr(spr_addr),
    .spr_wdata(spr_wdata), .spr_ack(spr_ack), .spr_rdata(spr_rdata),
    .rsp_valid(win_rsp), .rsp_rdata(win_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrsp_q <= 1'b0;
      lrd_q  <= '0;
    end else begin
      lrsp_q <= lrsp_d;
      if (local_hit) lrd_q <= lrd_d;
    end
  end

  assign rsp_valid = lrsp_q | win_rsp;
  assign rsp_rdata = win_rsp ? win_rd : lrd_q;

endmodule

// File: rtl/dbg_spr_bridge_chk.sv
module dbg_spr_bridge_chk
  import dbg_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  localparam int SPR_AW = REG_W + ADDR_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              spr_req,
  input logic              spr_ack,
  input logic              spr_write,
  input logic [SPR_AW-1:0] spr_addr,
  input logic [DATA_W-1:0] spr_wdata,
  input logic              core_stall,
  input logic [REG_W-1:0]  width_val
);

  p_stall_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall != $past(core_stall)) |->
      $past(req_valid && req_write && req_addr == A_CTRL));

  p_width_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (width_val == '0) || width_legal(width_val));

  p_local_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[ADDR_W-1]) |=> rsp_valid);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_win_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1]) |=> (spr_req && !rsp_valid));

  p_win_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_req && !spr_ack) |=>
      (spr_req && $stable(spr_addr) && $stable(spr_write) && $stable(spr_wdata)));

  p_win_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_req && spr_ack) |=> (!spr_req && rsp_valid));

endmodule

bind dbg_spr_bridge dbg_spr_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .spr_req(spr_req),
  .spr_ack(spr_ack), .spr_write(spr_write), .spr_addr(spr_addr),
  .spr_wdata(spr_wdata), .core_stall(core_stall), .width_val(width_q)
);

// File: tb/test_dbg_spr_bridge.sv
module test_dbg_spr_bridge;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        spr_req, spr_write, spr_ack;
  logic [30:0] spr_addr;
  logic [31:0] spr_wdata, spr_rdata;
  logic        core_stall;

  int nchk = 0, nerr = 0, cyc = 0, ack_delay = 0, ack_cnt = 0;
  bit finished = 0;
  logic [30:0] seen_addr;
  logic        seen_wr;
  logic [31:0] seen_wd;

  dbg_spr_bridge i_dbg_spr_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .spr_req(spr_req), .spr_write(spr_write),
    .spr_addr(spr_addr), .spr_wdata(spr_wdata), .spr_ack(spr_ack),
    .spr_rdata(spr_rdata), .core_stall(core_stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] core_val(input logic [30:0] a);
    return {a[15:0], ~a[30:15]};
  endfunction

  // core model: acknowledges after ack_delay cycles
  always @(negedge clk) begin
    if (spr_req && !spr_ack) begin
      if (ack_cnt >= ack_delay) begin
        spr_ack   = 1'b1;
        spr_rdata = core_val(spr_addr);
        seen_addr = spr_addr;
        seen_wr   = spr_write;
        seen_wd   = spr_wdata;
        ack_cnt   = 0;
      end else ack_cnt++;
    end else begin
      spr_ack = 1'b0;
    end
  end

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      nchk++; nerr++;
      $display("FAIL R8 watchdog: actual=hung expected=completion");
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  task automatic lwrite(input logic [15:0] a, input logic [31:0] wd);
    logic [31:0] rd; int lat;
    access(1'b1, a, wd, rd, lat);
    chk("R8 write latency", 32'(lat), 32'd1);
    chk("R8 write data", rd, 32'h0);
  endtask

  task automatic lread(input logic [15:0] a, input logic [15:0] exp, input string req);
    logic [31:0] rd; int lat;
    access(1'b0, a, 32'h0, rd, lat);
    chk("R8 read latency", 32'(lat), 32'd1);
    chk(req, rd, {16'h0, exp});
  endtask

  logic [15:0] m_status, m_evdest, m_ctrl, m_upper, m_width;

  initial begin
    logic [15:0] pats [6];
    logic [15:0] wins [6];
    logic [15:0] ups [4];
    pats = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h0001, 16'h8000};
    wins = '{16'h8000, 16'h8001, 16'hFFFF, 16'hC3A5, 16'hA000, 16'h9234};
    ups  = '{16'h0000, 16'h0001, 16'h5A5A, 16'hFFFF};
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    spr_ack = 0; spr_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset stall", {31'h0, core_stall}, 32'h0);
    chk("R8 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R9 reset spr_req", {31'h0, spr_req}, 32'h0);

    // R1 identity, R2/R3/R5/R6 reset values
    lread(16'h0000, 16'h0001, "R1 vendor");
    lread(16'h0001, 16'h0006, "R1 type");
    lread(16'h0002, 16'h0000, "R1 version");
    lread(16'h0003, 16'h0000, "R2 reset 0x3");
    lread(16'h0004, 16'h0000, "R2 reset 0x4");
    lread(16'h0200, 16'h0000, "R3 reset ctrl");
    lread(16'h0201, 16'h0000, "R5 reset upper");
    lread(16'h0202, 16'h0000, "R6 reset width");
    for (int i = 0; i < 6; i++) begin
      lwrite(16'h0000 + 16'(i % 3), {16'h0, pats[i]});
      lread(16'h0000, 16'h0001, "R1 vendor after write");
      lread(16'h0001, 16'h0006, "R1 type after write");
      lread(16'h0002, 16'h0000, "R1 version after write");
    end

    // R2, R3, R4, R5 pattern sweep
    m_ctrl = 0;
    for (int i = 0; i < 6; i++) begin
      lwrite(16'h0003, {16'hDEAD, pats[i]});
      lread(16'h0003, pats[i], "R2 rw 0x3");
      lwrite(16'h0004, {16'h0, ~pats[i]});
      lread(16'h0004, ~pats[i], "R2 rw 0x4");
      lwrite(16'h0200, {16'h0, pats[i]});
      chk("R4 stall follows write", {31'h0, core_stall}, {31'h0, pats[i][0]});
      lread(16'h0200, pats[i], "R3 rw ctrl");
      lread(16'h0003, pats[i], "R4 stall unchanged by other access");
      chk("R4 stall held", {31'h0, core_stall}, {31'h0, pats[i][0]});
      lwrite(16'h0201, {16'h0, pats[i] ^ 16'h3C3C});
      lread(16'h0201, pats[i] ^ 16'h3C3C, "R5 rw upper");
    end
    m_status = 16'h8000; m_evdest = 16'h7FFF; m_ctrl = 16'h8000; m_upper = 16'hBC3C;

    // R6 width filter sweep
    m_width = 0;
    for (int v = 0; v < 300; v++) begin
      lwrite(16'h0202, 32'(v));
      if (v == 16 || v == 32 || v == 64 || v == 128) m_width = 16'(v);
      lread(16'h0202, m_width, "R6 width filter");
    end
    lwrite(16'h0202, 32'h0001_0010);
    lread(16'h0202, 16'h0010, "R6 width low half 16");

    // R7 unmapped sweep
    for (int a = 5; a < 32768; a += 97) begin
      if (a >= 16'h0200 && a <= 16'h0202) continue;
      lwrite(16'(a), 32'h0000_BEEF);
      lread(16'(a), 16'h0000, "R7 unmapped reads zero");
    end
    lread(16'h0003, m_status, "R7 status untouched");
    lread(16'h0004, m_evdest, "R7 evdest untouched");
    lread(16'h0200, m_ctrl, "R7 ctrl untouched");
    lread(16'h0201, m_upper, "R7 upper untouched");
    lread(16'h0202, 16'h0010, "R7 width untouched");

    // R9 / R10 window sweep
    for (int u = 0; u < 4; u++) begin
      lwrite(16'h0201, {16'h0, ups[u]});
      for (int w = 0; w < 6; w++) begin
        for (int k = 0; k < 2; k++) begin
          logic [31:0] rd, wd; logic [30:0] ea; int lat;
          ack_delay = (u + w + k) % 4;
          wd = {wins[w], ups[u]} ^ 32'h1357_9BDF;
          ea = 31'(ups[u]) * 31'd32768 + 31'(wins[w] - 16'h8000);
          access(k[0], wins[w], wd, rd, lat);
          chk("R10 window latency", 32'(lat), 32'(ack_delay + 2));
          chk("R9 spr address", {1'b0, seen_addr}, {1'b0, ea});
          chk("R9 spr write flag", {31'h0, seen_wr}, {31'h0, k[0]});
          if (k[0]) begin
            chk("R9 spr write data", seen_wd, wd);
            chk("R10 write response data", rd, 32'h0);
          end else begin
            chk("R10 read response data", rd, core_val(ea));
          end
          chk("R10 spr_req dropped", {31'h0, spr_req}, 32'h0);
        end
      end
    end
    lread(16'h0200, m_ctrl, "R4 ctrl untouched by window");
    chk("R4 stall untouched by window", {31'h0, core_stall}, {31'h0, m_ctrl[0]});

    summary();
  end

endmodule